// File: doc/BRIEF.md
# IDE Register Bridge with Interrupt Latch

This block sits between a simple little-endian register bus and the task-file logic of a two-drive IDE channel. It claims a 4 KiB window. The register index is taken from the address with the low four bits dropped, so registers are spaced 16 bytes apart. Each register answers to exactly one legal access size, or to a small set of them. Legal accesses to the data port, the seven task-file registers and the alternate-status/device-control register are forwarded as single-cycle strobes on a task-file port. Read data from that port is sampled in the same cycle. A read that matches no legal register and size returns all ones. A write that matches none is dropped.

The block also owns two 32-bit registers. The first is a timing register that the bus writes and reads back. The second is an interrupt status word. In that word, the DMA interrupt bit is latched and cleared by writing a one to it. The disk interrupt bit follows the disk line. Both interrupt inputs also pass straight through to their own outputs, so the interrupt controller sees the lines with no added delay.

Top module: `ide_mmio_bridge`

## Requirements
- R1: After a synchronous active-low reset, a 4-byte read of the timing register (index 0x20) returns 0, and a 4-byte read of the interrupt status register (index 0x30) returns 0 while both interrupt inputs are low. Before any read, `bus_rdata` holds 0xFFFFFFFF.
- R2: A read with size code 3, to an unmapped index, or with a size the register does not accept returns 0xFFFFFFFF. Such an access raises neither `tf_rd` nor `tf_wr`. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R3: Index 0 is the data port. A 1-byte read uses kind 0 (16-bit data) and returns `tf_rdata[7:0]` zero-extended. A 2-byte access uses kind 0 and moves bits 15:0. A 4-byte access uses kind 1 (32-bit data) and moves all 32 bits. A 1-byte write raises no strobe.
- R4: Indices 1 to 7 are task-file registers, reachable only with 1-byte accesses. They use kind 2 with `tf_idx` equal to the index. A read returns `tf_rdata[7:0]` zero-extended.
- R5: Indices 0x08 and 0x16 both select kind 3 for 1-byte accesses: alternate status on a read and device control on a write. A read returns `tf_rdata[7:0]` zero-extended.
- R6: The timing register at index 0x20 is written and read only by 4-byte accesses. It reads back the last value written. Accesses of any other size leave it unchanged.
- R7: Bit 30 of the interrupt status word equals the disk interrupt input as sampled at the previous clock edge.
- R8: Bit 31 of the interrupt status word is set when the DMA input rises and cleared when it falls. A 4-byte write to index 0x30 with data bit 31 set also clears it. A rise in the same cycle as that write wins, and the bit ends up set. All other written bits are ignored, and a write with bit 31 clear changes nothing.
- R9: `irq_dma_out` equals `irq_dma_in`, and `irq_disk_out` equals `irq_disk_in`, in the same cycle.
- R10: Read data appears on `bus_rdata` after the clock edge that accepts the read. It then holds until the next read.
- R11: Address bits 3:0 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| bus_wdata | input | 32 | Write data, little-endian, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_kind | output | 2 | 0 = data 16-bit, 1 = data 32-bit, 2 = task-file register, 3 = alternate status / device control |
| tf_idx | output | 3 | Task-file register number for kind 2 |
| tf_wdata | output | 32 | Write data toward the drive logic |
| tf_rdata | input | 32 | Read data from the drive logic, same cycle |
| irq_dma_in | input | 1 | DMA interrupt line |
| irq_disk_in | input | 1 | Disk interrupt line |
| irq_dma_out | output | 1 | Forwarded DMA interrupt |
| irq_disk_out | output | 1 | Forwarded disk interrupt |

## Verification
The task-file strobes, kind, index and the forwarded interrupts are combinational. The bench checks them one time unit after it drives the inputs, in the same cycle. Read data, timing-register updates and interrupt status updates all take effect at the next rising edge. The bench therefore updates its model at that edge and compares `bus_rdata` at the following falling edge, using the value the model held before the edge. Reads of the status word see the interrupt state from before the edge that accepts them, and the bench model follows the same one-cycle lag.

// File: rtl/ide_bridge_pkg.sv
// Package: shared encodings for the IDE register bridge.
// Assumes a register index of 8 bits (12-bit window, 16-byte spacing).
package ide_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TFK_DATA16 = 2'd0,
        TFK_DATA32 = 2'd1,
        TFK_TASK   = 2'd2,
        TFK_CTRL   = 2'd3
    } tf_kind_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_DATA   = 3'd1,
        SEL_TASK   = 3'd2,
        SEL_CTRL   = 3'd3,
        SEL_TIMING = 3'd4,
        SEL_IRQ    = 3'd5
    } reg_sel_e;

    localparam logic [7:0] IDX_DATA     = 8'h00;
    localparam logic [7:0] IDX_TASK_LO  = 8'h01;
    localparam logic [7:0] IDX_TASK_HI  = 8'h07;
    localparam logic [7:0] IDX_CTRL_A   = 8'h08;
    localparam logic [7:0] IDX_CTRL_B   = 8'h16;
    localparam logic [7:0] IDX_TIMING   = 8'h20;
    localparam logic [7:0] IDX_IRQ      = 8'h30;

endpackage

// File: rtl/ide_addr_decode.sv
// Module: ide_addr_decode
// Turns one bus request (index, size, direction) into a register select,
// legality flags and task-file strobes. Purely combinational.
// Assumes the caller has already dropped the in-register offset bits.
module ide_addr_decode
    import ide_bridge_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             req,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output reg_sel_e         sel,
    output logic             legal_rd,
    output logic             legal_wr,
    output logic             tf_rd,
    output logic             tf_wr,
    output logic [1:0]       tf_kind,
    output logic [2:0]       tf_idx,
    output logic             timing_wr,
    output logic             irq_wr
);

    logic is_byte, is_half, is_word;

    // Size classification of the current access.
    always_comb begin
        is_byte = (size == SZ_BYTE);
        is_half = (size == SZ_HALF);
        is_word = (size == SZ_WORD);
    end

    // Map the index onto one register group.
    always_comb begin
        sel = SEL_NONE;
        if (idx == IDX_W'(IDX_DATA))
            sel = SEL_DATA;
        else if (idx >= IDX_W'(IDX_TASK_LO) && idx <= IDX_W'(IDX_TASK_HI))
            sel = SEL_TASK;
        else if (idx == IDX_W'(IDX_CTRL_A) || idx == IDX_W'(IDX_CTRL_B))
            sel = SEL_CTRL;
        else if (idx == IDX_W'(IDX_TIMING))
            sel = SEL_TIMING;
        else if (idx == IDX_W'(IDX_IRQ))
            sel = SEL_IRQ;
    end

    // Decide which sizes each group accepts, per direction.
    always_comb begin
        legal_rd = 1'b0;
        legal_wr = 1'b0;
        unique case (sel)
            SEL_DATA: begin
                legal_rd = is_byte | is_half | is_word;
                legal_wr = is_half | is_word;
            end
            SEL_TASK, SEL_CTRL: begin
                legal_rd = is_byte;
                legal_wr = is_byte;
            end
            SEL_TIMING, SEL_IRQ: begin
                legal_rd = is_word;
                legal_wr = is_word;
            end
            default: ;
        endcase
    end

    // Drive task-file strobes and local register write enables.
    always_comb begin
        tf_rd     = 1'b0;
        tf_wr     = 1'b0;
        timing_wr = 1'b0;
        irq_wr    = 1'b0;
        tf_kind   = TFK_DATA16;
        tf_idx    = 3'd0;
        unique case (sel)
            SEL_DATA: tf_kind = is_word ? TFK_DATA32 : TFK_DATA16;
            SEL_TASK: begin
                tf_kind = TFK_TASK;
                tf_idx  = idx[2:0];
            end
            SEL_CTRL: tf_kind = TFK_CTRL;
            default: ;
        endcase
        if (req) begin
            if (sel == SEL_DATA || sel == SEL_TASK || sel == SEL_CTRL) begin
                tf_rd = !we && legal_rd;
                tf_wr = we && legal_wr;
            end
            timing_wr = we && legal_wr && (sel == SEL_TIMING);
            irq_wr    = we && legal_wr && (sel == SEL_IRQ);
        end
    end

endmodule

// File: rtl/ide_cfg_reg.sv
// Module: ide_cfg_reg
// A plain read/write configuration register, cleared by reset.
// Assumes the write enable is already qualified by address and size.
module ide_cfg_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    // Capture write data on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_data;
    end

endmodule

// File: rtl/ide_irq_latch.sv
// Module: ide_irq_latch
// Interrupt status word. Line n owns bit W-1-n. A rising input sets the bit
// and a falling input clears it. Lines marked in CLR_MASK may also be cleared
// by software, and a rising edge in the same cycle wins over that clear.
// Assumes inputs are synchronous to clk.
module ide_irq_latch #(
    parameter int            W        = 32,
    parameter int            LINES    = 2,
    parameter logic [LINES-1:0] CLR_MASK = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] sw_clr,
    output logic [W-1:0]     stat
);

    logic [LINES-1:0] line_prev;

    // Remember each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_prev <= '0;
        else
            line_prev <= line_in;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        localparam int BIT = W - 1 - n;
        logic rise, fall, clr;

        // Edge and clear qualifiers for this line.
        always_comb begin
            rise = line_in[n] & ~line_prev[n];
            fall = ~line_in[n] & line_prev[n];
            clr  = CLR_MASK[n] ? sw_clr[n] : 1'b0;
        end

        // Update this line's status bit, rise taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat[BIT] <= 1'b0;
            else if (rise)
                stat[BIT] <= 1'b1;
            else if (fall || clr)
                stat[BIT] <= 1'b0;
        end
    end

    // Bits with no interrupt line stay zero.
    always_comb begin
        stat[W-LINES-1:0] = '0;
    end

endmodule

// File: rtl/ide_mmio_bridge.sv
// Module: ide_mmio_bridge (top)
// Register-bus front end for a two-drive IDE channel. It decodes index and
// size, forwards legal accesses to the task-file port, and holds a timing
// register and an interrupt status word. Read data is registered.
// Assumes tf_rdata is valid in the same cycle as tf_rd.
module ide_mmio_bridge
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int IDX_SHIFT = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic [1:0]        tf_kind,
    output logic [2:0]        tf_idx,
    output logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] tf_rdata,
    input  logic              irq_dma_in,
    input  logic              irq_disk_in,
    output logic              irq_dma_out,
    output logic              irq_disk_out
);

    localparam int IDX_W = ADDR_W - IDX_SHIFT;
    localparam int IRQ_LINES = 2;

    reg_sel_e          sel;
    logic              legal_rd, legal_wr;
    logic              timing_wr, irq_wr;
    logic [DATA_W-1:0] timing_q;
    logic [DATA_W-1:0] irq_stat;
    logic [DATA_W-1:0] rd_val;
    logic [IRQ_LINES-1:0] irq_lines, irq_clr;
    logic              unused_addr_lo;

    // Offset bits inside a register slot play no part in decoding.
    assign unused_addr_lo = ^bus_addr[IDX_SHIFT-1:0];

    ide_addr_decode #(.IDX_W(IDX_W)) u_dec (
        .req       (bus_req),
        .we        (bus_we),
        .idx       (bus_addr[ADDR_W-1:IDX_SHIFT]),
        .size      (bus_size),
        .sel       (sel),
        .legal_rd  (legal_rd),
        .legal_wr  (legal_wr),
        .tf_rd     (tf_rd),
        .tf_wr     (tf_wr),
        .tf_kind   (tf_kind),
        .tf_idx    (tf_idx),
        .timing_wr (timing_wr),
        .irq_wr    (irq_wr)
    );

    ide_cfg_reg #(.W(DATA_W)) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (timing_wr),
        .wr_data (bus_wdata),
        .q       (timing_q)
    );

    // Line 0 is DMA (bit 31, clearable), line 1 is disk (bit 30).
    always_comb begin
        irq_lines = {irq_disk_in, irq_dma_in};
        irq_clr   = {1'b0, irq_wr & bus_wdata[DATA_W-1]};
    end

    ide_irq_latch #(
        .W        (DATA_W),
        .LINES    (IRQ_LINES),
        .CLR_MASK (2'b01)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (irq_lines),
        .sw_clr  (irq_clr),
        .stat    (irq_stat)
    );

    // Interrupt lines are forwarded without delay.
    always_comb begin
        irq_dma_out  = irq_dma_in;
        irq_disk_out = irq_disk_in;
    end

    // Write data goes to the drive logic unchanged.
    assign tf_wdata = bus_wdata;

    // Select the read value for the current access.
    always_comb begin
        rd_val = '1;
        if (legal_rd) begin
            unique case (sel)
                SEL_DATA: begin
                    if (bus_size == SZ_BYTE)
                        rd_val = DATA_W'(tf_rdata[7:0]);
                    else if (bus_size == SZ_HALF)
                        rd_val = DATA_W'(tf_rdata[15:0]);
                    else
                        rd_val = tf_rdata;
                end
                SEL_TASK, SEL_CTRL: rd_val = DATA_W'(tf_rdata[7:0]);
                SEL_TIMING:         rd_val = timing_q;
                SEL_IRQ:            rd_val = irq_stat;
                default:            rd_val = '1;
            endcase
        end
    end

    // Register read data on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '1;
        else if (bus_req && !bus_we)
            bus_rdata <= rd_val;
    end

endmodule

// File: rtl/ide_mmio_bridge_chk.sv
// Module: ide_mmio_bridge_chk
// Assertion checker for ide_mmio_bridge, attached by bind. It keeps its own
// sampled copy of the DMA line and its own write decode from the bus ports.
module ide_mmio_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic        tf_rd,
    input logic        tf_wr,
    input logic        irq_dma_in,
    input logic        irq_disk_in,
    input logic        irq_dma_out,
    input logic        irq_disk_out,
    input logic [31:0] irq_stat,
    input logic [31:0] timing_q
);

    logic dma_seen;
    logic w1c_hit, tim_hit;

    // Own copy of the previous DMA line value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_seen <= 1'b0;
        else
            dma_seen <= irq_dma_in;
    end

    // Bus-side decode of writes to the two local registers.
    always_comb begin
        w1c_hit = bus_req && bus_we && bus_size == 2'd2 &&
                  bus_addr[11:4] == 8'h30 && bus_wdata[31];
        tim_hit = bus_req && bus_we && bus_size == 2'd2 &&
                  bus_addr[11:4] == 8'h20;
    end

    AST_RSVD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'd3) |-> (!tf_rd && !tf_wr)); // R2

    AST_IRQ_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dma_out == irq_dma_in) && (irq_disk_out == irq_disk_in)); // R9

    AST_DISK_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_stat[30] == $past(irq_disk_in))); // R7

    AST_DMA_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(w1c_hit) && !$past(irq_dma_in && !dma_seen))
        |-> !irq_stat[31]); // R8

    AST_DMA_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_dma_in && !dma_seen)) |-> irq_stat[31]); // R8

    AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tim_hit)) |-> $stable(timing_q)); // R6

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat[29:0] == 30'd0); // R8

endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .tf_rd        (tf_rd),
    .tf_wr        (tf_wr),
    .irq_dma_in   (irq_dma_in),
    .irq_disk_in  (irq_disk_in),
    .irq_dma_out  (irq_dma_out),
    .irq_disk_out (irq_disk_out),
    .irq_stat     (irq_stat),
    .timing_q     (timing_q)
);

// File: tb/ide_mmio_bridge_tb_top.sv
// Bench for ide_mmio_bridge: directed corners plus seeded random accesses,
// each compared against a bench-side model of the register map.
module ide_mmio_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tf_rd, tf_wr;
    logic [1:0]  tf_kind;
    logic [2:0]  tf_idx;
    logic [31:0] tf_wdata;
    logic [31:0] tf_rdata = '0;
    logic        irq_dma_in = 1'b0, irq_disk_in = 1'b0;
    logic        irq_dma_out, irq_disk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [31:0] m_timing, m_rdata;
    logic        m_b31, m_b30, m_dprev;

    always #2.5 clk = ~clk;

    ide_mmio_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tf_rd(tf_rd), .tf_wr(tf_wr),
        .tf_kind(tf_kind), .tf_idx(tf_idx), .tf_wdata(tf_wdata),
        .tf_rdata(tf_rdata), .irq_dma_in(irq_dma_in),
        .irq_disk_in(irq_disk_in), .irq_dma_out(irq_dma_out),
        .irq_disk_out(irq_disk_out)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Requirement tag for an index.
    function automatic string tag_of(input logic [7:0] idx);
        if (idx == 8'h00) return "R3";
        if (idx >= 8'h01 && idx <= 8'h07) return "R4";
        if (idx == 8'h08 || idx == 8'h16) return "R5";
        if (idx == 8'h20) return "R6";
        if (idx == 8'h30) return "R8";
        return "R2";
    endfunction

    function automatic bit is_tf(input logic [7:0] idx);
        return idx <= 8'h08 || idx == 8'h16;
    endfunction

    function automatic bit ok_rd(input logic [7:0] idx, input logic [1:0] sz);
        if (idx == 8'h00) return sz != 2'd3;
        if (idx <= 8'h08 || idx == 8'h16) return sz == 2'd0;
        if (idx == 8'h20 || idx == 8'h30) return sz == 2'd2;
        return 1'b0;
    endfunction

    function automatic bit ok_wr(input logic [7:0] idx, input logic [1:0] sz);
        if (idx == 8'h00) return sz == 2'd1 || sz == 2'd2;
        return ok_rd(idx, sz);
    endfunction

    // One bus cycle: drive at negedge, check combinational outputs,
    // advance the model at posedge, check registered data at next negedge.
    task automatic cycle(input bit req, input bit we, input logic [11:0] addr,
                         input logic [1:0] sz, input logic [31:0] wd,
                         input bit dma, input bit disk);
        logic [7:0]  idx;
        logic [31:0] rv;
        bit          e_rd, e_wr, rise, fall, w1c;
        logic [1:0]  e_kind;
        idx = addr[11:4];
        bus_req = req; bus_we = we; bus_addr = addr; bus_size = sz;
        bus_wdata = wd; irq_dma_in = dma; irq_disk_in = disk;
        tf_rdata = $urandom;
        #1;
        chk(irq_dma_out == dma && irq_disk_out == disk, "R9",
            {30'd0, irq_disk_out, irq_dma_out}, {30'd0, disk, dma});
        e_rd = req && !we && is_tf(idx) && ok_rd(idx, sz);
        e_wr = req && we && is_tf(idx) && ok_wr(idx, sz);
        chk(tf_rd == e_rd && tf_wr == e_wr,
            (sz == 2'd3 || !ok_rd(idx, sz)) ? "R2" : tag_of(idx),
            {30'd0, tf_rd, tf_wr}, {30'd0, e_rd, e_wr});
        if (e_rd || e_wr) begin
            e_kind = (idx == 8'h00) ? ((sz == 2'd2) ? 2'd1 : 2'd0) :
                     (idx <= 8'h07) ? 2'd2 : 2'd3;
            chk(tf_kind == e_kind, tag_of(idx), {30'd0, tf_kind}, {30'd0, e_kind});
            if (e_kind == 2'd2)
                chk(tf_idx == idx[2:0], "R4", {29'd0, tf_idx}, {29'd0, idx[2:0]});
            if (e_wr)
                chk(tf_wdata == wd, tag_of(idx), tf_wdata, wd);
        end
        // expected read value from model state before the edge
        rv = 32'hFFFF_FFFF;
        if (ok_rd(idx, sz)) begin
            if (idx == 8'h00)
                rv = (sz == 2'd0) ? {24'd0, tf_rdata[7:0]} :
                     (sz == 2'd1) ? {16'd0, tf_rdata[15:0]} : tf_rdata;
            else if (is_tf(idx)) rv = {24'd0, tf_rdata[7:0]};
            else if (idx == 8'h20) rv = m_timing;
            else rv = {m_b31, m_b30, 30'd0};
        end
        if (req && !we) m_rdata = rv;
        if (req && we && idx == 8'h20 && sz == 2'd2) m_timing = wd;
        rise = dma && !m_dprev;
        fall = !dma && m_dprev;
        w1c  = req && we && idx == 8'h30 && sz == 2'd2 && wd[31];
        if (rise) m_b31 = 1'b1;
        else if (fall || w1c) m_b31 = 1'b0;
        m_b30 = disk;
        m_dprev = dma;
        @(posedge clk);
        @(negedge clk);
        chk(bus_rdata == m_rdata,
            (req && !we) ? ((sz == 2'd3 || !ok_rd(idx, sz)) ? "R2" : tag_of(idx)) : "R10",
            bus_rdata, m_rdata);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pick [12];
        void'($urandom(32'd20240607));
        m_timing = '0; m_rdata = 32'hFFFF_FFFF;
        m_b31 = 1'b0; m_b30 = 1'b0; m_dprev = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(bus_rdata == 32'hFFFF_FFFF, "R1", bus_rdata, 32'hFFFF_FFFF);
        cycle(1, 0, 12'h200, 2'd2, 0, 0, 0);                   // R1 timing = 0
        cycle(1, 0, 12'h300, 2'd2, 0, 0, 0);                   // R1 irq = 0
        // R3 data port widths, R11 offset bits ignored
        cycle(1, 0, 12'h00F, 2'd0, 0, 0, 0);
        cycle(1, 0, 12'h005, 2'd1, 0, 0, 0);
        cycle(1, 0, 12'h000, 2'd2, 0, 0, 0);
        cycle(1, 1, 12'h000, 2'd0, 32'hAB, 0, 0);              // R3 byte write dropped
        cycle(1, 1, 12'h003, 2'd2, 32'h1234_5678, 0, 0);
        // R4/R5 task-file and control
        cycle(1, 1, 12'h07A, 2'd0, 32'h5A, 0, 0);
        cycle(1, 0, 12'h031, 2'd1, 0, 0, 0);                   // R4 wrong size
        cycle(1, 0, 12'h16C, 2'd0, 0, 0, 0);                   // R5 alias
        cycle(1, 1, 12'h080, 2'd0, 32'h06, 0, 0);
        // R6 timing
        cycle(1, 1, 12'h204, 2'd2, 32'hCAFE_F00D, 0, 0);
        cycle(1, 1, 12'h200, 2'd0, 32'h0000_0011, 0, 0);       // R6 byte write ignored
        cycle(1, 0, 12'h200, 2'd2, 0, 0, 0);
        cycle(1, 0, 12'h200, 2'd1, 0, 0, 0);                   // R2 half read illegal
        // R2 reserved size and unmapped
        cycle(1, 0, 12'h000, 2'd3, 0, 0, 0);
        cycle(1, 0, 12'hFF0, 2'd2, 0, 0, 0);
        // R7/R8 interrupt behaviour
        cycle(0, 0, 0, 0, 0, 1, 1);                            // rises
        cycle(1, 0, 12'h300, 2'd2, 0, 1, 1);
        cycle(1, 1, 12'h300, 2'd2, 32'h7FFF_FFFF, 1, 1);       // R8 no bit31: no effect
        cycle(1, 0, 12'h300, 2'd2, 0, 1, 1);
        cycle(1, 1, 12'h300, 2'd2, 32'h8000_0000, 1, 1);       // R8 W1C while high
        cycle(1, 0, 12'h300, 2'd2, 0, 1, 0);
        cycle(1, 0, 12'h300, 2'd2, 0, 1, 0);                   // stays clear
        cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(1, 1, 12'h300, 2'd2, 32'hFFFF_FFFF, 1, 0);       // R8 rise beats clear
        cycle(1, 0, 12'h300, 2'd2, 0, 0, 1);                   // fall clears
        cycle(1, 0, 12'h300, 2'd2, 0, 0, 1);
        cycle(0, 0, 0, 0, 0, 0, 0);                            // R10 hold
        // random phase
        pick = '{8'h00, 8'h01, 8'h03, 8'h07, 8'h08, 8'h16,
                 8'h20, 8'h30, 8'h30, 8'h20, 8'h09, 8'h40};
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ix;
            ix = ($urandom_range(0, 9) == 0) ? 8'($urandom) : pick[$urandom_range(0, 11)];
            cycle($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1,
                  {ix, 4'($urandom)}, 2'($urandom),
                  ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
                  ($urandom_range(0, 2) == 0) ? ~irq_dma_in : irq_dma_in,
                  ($urandom_range(0, 2) == 0) ? ~irq_disk_in : irq_disk_in);
        end
        bus_req = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule